// File: doc/BRIEF.md
# Programmable Line Delay Buffer

This block delays a 10-bit sample stream by a number of clock cycles that can be set at run time. An 11-bit length code sets the delay. The delay in cycles is the code plus two, so the range runs from 2 to 2049 cycles. Every sample enters an input register and then passes through a circular store whose length is the code. It leaves through an output register. Those two registers provide the two fixed cycles of the delay.

A mode input chooses how the store is fed:
- **Pipeline mode:** the store takes a fresh input sample on every enabled edge.
- **Recirculation mode:** the store takes its own output, so a captured line keeps circulating.

Typical uses are line delays in video pipelines and repeating a stored line. An active-low clock enable freezes all state, and it acts one edge late because it is registered. An active-low output enable gates only the output port.

Top module: `line_delay_buf`

## Requirements
- R1: Synchronous active-high reset clears the input register, the output register, the length code (delay 2) and the internal enable, so the first edge after reset holds. With `out_en_n` low, `dout` reads 0 after reset.
- R2: With a loaded code C, a sample presented on `din` at enabled edge n appears on `dout` after enabled edge n+C+1. This is a total delay of C+2 enabled edges counting both ends. The store pointer wraps at C.
- R3: When `len_load_n` is low on an enabled edge, `len_code` becomes the new code. The sample taken on that same edge and every later one obey the new delay. Output between the load and the refill is undefined.
- R4: With `mode_recirc` low, the input register takes `din` on every enabled edge.
- R5: With `mode_recirc` high, `din` is ignored and the input register takes the current output. The stored line therefore repeats with a period of C+2 enabled edges.
- R6: `mode_recirc` may change on any edge. The store contents survive the switch, and the stream continues without a gap in either direction.
- R7: `clk_en_n` is sampled on every edge and governs the following edge. When the sampled value is high, that edge leaves all state unchanged, including the pointer, and ignores the load strobe.
- R8: While `out_en_n` is high, `dout` is 0 and `dout_valid` is low. The internal transfer of data continues, so the stream resumes in step when `out_en_n` returns low.
- R9: The largest code, 2047, yields a delay of 2049 edges in pipeline mode and a recirculation period of 2049 edges.
- R10: Code 0 bypasses the store and yields a delay of 2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 10 | Sample input |
| len_code | input | 11 | Length code, delay minus 2 |
| len_load_n | input | 1 | Length load strobe, active low |
| mode_recirc | input | 1 | 0 selects pipeline mode, 1 selects recirculation mode |
| clk_en_n | input | 1 | Clock enable, active low, registered |
| out_en_n | input | 1 | Output enable, active low |
| dout | output | 10 | Delayed sample, 0 while output is disabled |
| dout_valid | output | 1 | High while the output is enabled |

## Verification
A load strobe and a disabled edge can fall in the same cycle, as can a mode switch and a stream that is already circulating. The bench holds `len_load_n` low while the registered enable is low, then keeps comparing against a behavioural reference model. Any code wrongly captured by that strobe shows up as a delay mismatch on later samples. Mode is flipped both ways on a filled line, and every output sample afterwards is compared with the queue-based model, which carries the stream across the switch.

// File: rtl/ldb_pkg.sv
package ldb_pkg;

    parameter int LDB_DATA_W = 10;
    parameter int LDB_CODE_W = 11;
    parameter int LDB_FIXED  = 2;

    typedef enum logic {
        MODE_PIPE   = 1'b0,
        MODE_RECIRC = 1'b1
    } ldb_mode_e;

    function automatic int ldb_total_delay(input int code);
        return code + LDB_FIXED;
    endfunction

endpackage

// File: rtl/ldb_ctrl.sv
module ldb_ctrl #(
    parameter int CODE_W = ldb_pkg::LDB_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en_n,
    input  logic              len_load_n,
    input  logic [CODE_W-1:0] len_code,
    output logic              step,
    output logic              bypass,
    output logic [CODE_W-1:0] code_q,
    output logic [CODE_W-1:0] ptr
);

    logic              en_q;
    logic [CODE_W-1:0] last_pos;

    assign step     = en_q;
    assign bypass   = (code_q == '0);
    assign last_pos = code_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            code_q <= '0;
            ptr    <= '0;
        end else begin
            en_q <= ~clk_en_n;
            if (en_q) begin
                if (!len_load_n) begin
                    code_q <= len_code;
                    ptr    <= '0;
                end else if (bypass || ptr == last_pos) begin
                    ptr <= '0;
                end else begin
                    ptr <= ptr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ldb_store.sv
module ldb_store #(
    parameter int DATA_W = ldb_pkg::LDB_DATA_W,
    parameter int CODE_W = ldb_pkg::LDB_CODE_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [CODE_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << CODE_W;

    logic [DATA_W-1:0] cells [DEPTH];

    assign rdata = cells[addr];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

endmodule

// File: rtl/line_delay_buf.sv
module line_delay_buf #(
    parameter int DATA_W = ldb_pkg::LDB_DATA_W,
    parameter int CODE_W = ldb_pkg::LDB_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  logic [CODE_W-1:0] len_code,
    input  logic              len_load_n,
    input  logic              mode_recirc,
    input  logic              clk_en_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);

    import ldb_pkg::*;

    logic              en_q;
    logic              bypass;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] ptr;
    logic [DATA_W-1:0] in_q;
    logic [DATA_W-1:0] out_q;
    logic [DATA_W-1:0] store_rd;
    logic [DATA_W-1:0] src;
    ldb_mode_e         mode;

    assign mode = ldb_mode_e'(mode_recirc);

    ldb_ctrl #(.CODE_W(CODE_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clk_en_n   (clk_en_n),
        .len_load_n (len_load_n),
        .len_code   (len_code),
        .step       (en_q),
        .bypass     (bypass),
        .code_q     (code_q),
        .ptr        (ptr)
    );

    ldb_store #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_store (
        .clk   (clk),
        .we    (en_q && !bypass),
        .addr  (ptr),
        .wdata (in_q),
        .rdata (store_rd)
    );

    always_comb begin
        case (mode)
            MODE_RECIRC: src = out_q;
            default:     src = din;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            out_q <= '0;
        end else if (en_q) begin
            in_q  <= src;
            out_q <= bypass ? in_q : store_rd;
        end
    end

    assign dout       = out_en_n ? '0 : out_q;
    assign dout_valid = ~out_en_n;

endmodule

// File: rtl/ldb_checker.sv
module ldb_checker #(
    parameter int DATA_W = ldb_pkg::LDB_DATA_W,
    parameter int CODE_W = ldb_pkg::LDB_CODE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] din,
    input logic [CODE_W-1:0] len_code,
    input logic              len_load_n,
    input logic              mode_recirc,
    input logic              clk_en_n,
    input logic              out_en_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid,
    input logic              en_q,
    input logic [CODE_W-1:0] code_q,
    input logic [CODE_W-1:0] ptr,
    input logic [DATA_W-1:0] in_q,
    input logic [DATA_W-1:0] out_q
);

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (code_q != '0) |-> (ptr < code_q)); // R2

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (en_q && !len_load_n) |=> (code_q == $past(len_code))); // R3

    AST_PIPE_TAKES_DIN: assert property (@(posedge clk) disable iff (rst)
        (en_q && !mode_recirc) |=> (in_q == $past(din))); // R4

    AST_RECIRC_FEEDBACK: assert property (@(posedge clk) disable iff (rst)
        (en_q && mode_recirc) |=> (in_q == $past(out_q))); // R5

    AST_ENABLE_LATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ##1 ($stable(out_q) && $stable(ptr) && $stable(code_q))); // R7

    AST_OUTPUT_GATED: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> (dout == '0 && !dout_valid)); // R8

endmodule

bind line_delay_buf ldb_checker #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_ldb_chk (
    .clk         (clk),
    .rst         (rst),
    .din         (din),
    .len_code    (len_code),
    .len_load_n  (len_load_n),
    .mode_recirc (mode_recirc),
    .clk_en_n    (clk_en_n),
    .out_en_n    (out_en_n),
    .dout        (dout),
    .dout_valid  (dout_valid),
    .en_q        (en_q),
    .code_q      (code_q),
    .ptr         (ptr),
    .in_q        (in_q),
    .out_q       (out_q)
);

// File: tb/test_line_delay_buf.sv
module test_line_delay_buf;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  din = '0;
    logic [10:0] len_code = '0;
    logic        len_load_n = 1'b1;
    logic        mode_recirc = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        out_en_n = 1'b0;
    logic [9:0]  dout;
    logic        dout_valid;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    logic [9:0] hist[$];
    int         dly = 2;
    bit         en_m = 1'b0;

    always #10 clk = ~clk;

    line_delay_buf i_line_delay_buf (
        .clk         (clk),
        .rst         (rst),
        .din         (din),
        .len_code    (len_code),
        .len_load_n  (len_load_n),
        .mode_recirc (mode_recirc),
        .clk_en_n    (clk_en_n),
        .out_en_n    (out_en_n),
        .dout        (dout),
        .dout_valid  (dout_valid)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: a queue of samples entering the input stage.
    always @(posedge clk) begin
        logic [9:0] cur;
        logic [9:0] src;
        if (rst) begin
            en_m = 1'b0;
            dly  = 2;
            hist.delete();
            hist.push_back('0);
            hist.push_back('0);
        end else begin
            if (en_m) begin
                cur = (hist.size() >= dly) ? hist[hist.size() - dly] : 'x;
                src = mode_recirc ? cur : din;
                if (!len_load_n) begin
                    hist.delete();
                    dly = int'(len_code) + 2;
                end
                hist.push_back(src);
                while (hist.size() > dly + 1) void'(hist.pop_front());
            end
            en_m = !clk_en_n;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done && hist.size() >= dly) begin
            check(cur_req, "dout", int'(dout),
                  out_en_n ? 0 : int'(hist[hist.size() - dly]));
            check(cur_req, "dout_valid", int'(dout_valid), out_en_n ? 0 : 1);
        end
    end

    task automatic cyc(input int n, input bit rnd);
        for (int i = 0; i < n; i++) begin
            if (rnd) din = 10'($urandom);
            @(posedge clk);
            #4;
        end
    endtask

    task automatic load(input int code);
        len_code   = 11'(code);
        len_load_n = 1'b0;
        cyc(1, 1'b1);
        len_load_n = 1'b1;
        len_code   = 11'($urandom);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #4;
        rst = 1'b0;
        cur_req = "R1";
        @(negedge clk);
        check("R1", "reset dout", int'(dout), 0);
        check("R1", "reset dout_valid", int'(dout_valid), 1);
        #4;

        // R10: code 0, delay of 2 with the store bypassed
        cur_req = "R10";
        cyc(25, 1'b1);

        // R3 and R2: load a short delay, pointer wraps at 5
        cur_req = "R3";
        load(5);
        cur_req = "R2";
        cyc(40, 1'b1);

        // R7: registered enable, strobe offered while disabled
        cur_req = "R7";
        for (int i = 0; i < 40; i++) begin
            clk_en_n = ($urandom % 3) == 0;
            cyc(1, 1'b1);
        end
        clk_en_n = 1'b1;
        cyc(1, 1'b1);
        len_code   = 11'd300;
        len_load_n = 1'b0;
        cyc(1, 1'b1);
        len_load_n = 1'b1;
        clk_en_n   = 1'b0;
        cyc(20, 1'b1);

        // R8: output disabled, internal transfer continues
        cur_req = "R8";
        out_en_n = 1'b1;
        cyc(12, 1'b1);
        out_en_n = 1'b0;
        cyc(12, 1'b1);

        // R5 and R6: switch into recirculation on a filled line and back
        cur_req = "R5";
        mode_recirc = 1'b1;
        cyc(30, 1'b1);
        cur_req = "R6";
        clk_en_n = 1'b1;
        cyc(2, 1'b1);
        clk_en_n = 1'b0;
        mode_recirc = 1'b0;
        cyc(20, 1'b1);
        mode_recirc = 1'b1;
        cyc(15, 1'b1);
        mode_recirc = 1'b0;
        cyc(10, 1'b1);

        // R9: largest code
        cur_req = "R9";
        load(2047);
        cyc(2049 + 60, 1'b1);
        mode_recirc = 1'b1;
        cyc(2049 + 60, 1'b1);
        mode_recirc = 1'b0;

        // R4 and R2: smallest stored length
        cur_req = "R4";
        load(1);
        cyc(30, 1'b1);

        finish_run();
    end

endmodule